// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reset cause of a small low-power controller, clocked near 32 kHz, into one registered system reset. A power-on hold counter, an external reset pin, a pattern of four port inputs all high, a watchdog request and an oscillator-stop flag can each start a reset. The block drives an active-low internal reset and an active-high status pin that is high for as long as the reset lasts.

The external pin is filtered by a counter whose length is chosen at run time: 64 or 512 consecutive high samples. The filter is bypassed during the power-on hold, during sleep and for a short window after sleep ends, because the clock is not trusted in those phases. Asynchronous inputs are synchronized before use. A small cause register records which sources started the most recent reset, and reading it clears it.

Top module: `sysrst_ctrl`

## Requirements
- R1: While `rst_ni` is low, `status_o` is 1. After `rst_ni` rises, `status_o` stays 1 for exactly POR_CYCLES+1 clock edges (default 32768 hold cycles) and then falls if no other source is active.
- R2: With `deb_long_i` = 0 and no bypass, the pin causes a reset only after it has been high for 64 consecutive clocks. A high level of 63 clocks causes nothing. A low sample restarts the count.
- R3: With `deb_long_i` = 1, the pin must be high for 512 consecutive clocks. A high level of 511 clocks, or of 64 clocks, causes nothing.
- R4: During the power-on hold, while `sleep_i` is 1, and for WAKE_WIN clocks after `sleep_i` falls, any synchronized high sample of the pin causes a reset. A 2-clock pulse is enough.
- R5: When PORT_RST_EN is 1, `port_i` equal to 4'hF for two consecutive synchronized samples causes a reset. A single sample does not, and neither does any pattern with a bit low.
- R6: `wdog_req_i` high while `wdog_en_i` is 1 sets `status_o` at the next edge. With `wdog_en_i` = 0 the request is ignored.
- R7: A synchronized high on `osc_stop_i` causes a reset while `sleep_i` is 0 and is ignored while `sleep_i` is 1.
- R8: `status_o` falls one clock after the last active source drops. For the pin this is the third edge after the pin goes low, counting the two synchronizer stages.
- R9: `flags_o` records the sources active when a reset starts. The bits are 0 power-on, 1 pin, 2 port pattern, 3 watchdog and 4 oscillator stop. A new reset overwrites older flags. An asynchronous reset sets the flags to 5'b00001.
- R10: A `flag_rd_i` strobe clears `flags_o` at the next edge, unless a reset starts at that same edge.
- R11: `sys_rst_no` is always the inverse of `status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, about 32 kHz |
| rst_ni | input | 1 | Asynchronous active-low power-on event |
| pin_rst_i | input | 1 | External reset pin, active high, asynchronous |
| port_i | input | 4 | Port inputs watched for the all-high pattern, asynchronous |
| wdog_req_i | input | 1 | Watchdog timer reset request, synchronous |
| wdog_en_i | input | 1 | Software enable for the watchdog source |
| osc_stop_i | input | 1 | Oscillator-stopped flag from the analog detector, asynchronous |
| sleep_i | input | 1 | Device is in sleep mode |
| deb_long_i | input | 1 | Pin filter length select: 0 gives 64 clocks, 1 gives 512 clocks |
| flag_rd_i | input | 1 | Read strobe that clears the cause flags |
| flags_o | output | 5 | Cause flags of the most recent reset |
| sys_rst_no | output | 1 | Internal system reset, active low |
| status_o | output | 1 | External status pin, high during any reset |

## Verification
The hardest conditions to reach are the filter bypass windows: a short pin pulse has to land inside the few clocks after `sleep_i` falls, and a matching pulse has to land just after that window closes. The bench drops sleep and raises the pin on the same falling edge to test the first case. It then waits past WAKE_WIN and repeats the pulse to test the second. The filter thresholds are tested with held levels of exactly one clock below and exactly at each length, and the power-on hold length is counted edge by edge with a shortened counter parameter.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

  localparam int unsigned SRC_N = 5;

  // Bit positions of the cause vector; software decodes these.
  typedef enum int unsigned {
    SRC_POR  = 0,
    SRC_PIN  = 1,
    SRC_PORT = 2,
    SRC_WDOG = 3,
    SRC_OSC  = 4
  } src_idx_e;

  typedef logic [SRC_N-1:0] src_vec_t;

  localparam src_vec_t CAUSE_POR_ONLY = src_vec_t'(1) << SRC_POR;

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sysrst_por_timer.sv
module sysrst_por_timer #(
  parameter int unsigned POR_CYCLES = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic active_o
);

  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign active_o = (cnt_q != CW'(POR_CYCLES));
  assign cnt_en   = active_o;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sysrst_pin_filter.sv
module sysrst_pin_filter #(
  parameter int unsigned DEB_SHORT = 64,
  parameter int unsigned DEB_LONG  = 512,
  parameter int unsigned WAKE_WIN  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic long_sel_i,
  input  logic sleep_i,
  input  logic por_active_i,
  output logic req_o
);

  localparam int unsigned CW = $clog2(DEB_LONG + 1);
  localparam int unsigned WW = $clog2(WAKE_WIN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wake_q, wake_d;
  logic [CW-1:0] limit_m1;
  logic          bypass;
  logic          held_enough;

  // Consecutive-high counter; it saturates at the long length.
  always_comb begin
    if (!level_i)                      cnt_d = '0;
    else if (cnt_q != CW'(DEB_LONG))   cnt_d = cnt_q + 1'b1;
    else                               cnt_d = cnt_q;
  end

  // Bypass window: held while sleeping, counts down after wake.
  always_comb begin
    if (sleep_i)            wake_d = WW'(WAKE_WIN);
    else if (wake_q != '0)  wake_d = wake_q - 1'b1;
    else                    wake_d = wake_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wake_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      wake_q <= wake_d;
    end
  end

  // The current sample counts as one, so compare against length-1.
  assign limit_m1    = long_sel_i ? CW'(DEB_LONG - 1) : CW'(DEB_SHORT - 1);
  assign held_enough = (cnt_q >= limit_m1);
  assign bypass      = por_active_i | sleep_i | (wake_q != '0);
  assign req_o       = level_i & (bypass | held_enough);

endmodule

// File: rtl/sysrst_cause.sv
module sysrst_cause
  import sysrst_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     onset_i,
  input  src_vec_t src_i,
  input  logic     rd_i,
  output src_vec_t flags_o
);

  src_vec_t flags_q, flags_d;
  logic     flags_en;

  assign flags_en = onset_i | rd_i;

  always_comb begin
    if (onset_i) flags_d = src_i;
    else         flags_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= CAUSE_POR_ONLY;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
  import sysrst_pkg::*;
#(
  parameter int unsigned POR_CYCLES  = 32768,
  parameter int unsigned DEB_SHORT   = 64,
  parameter int unsigned DEB_LONG    = 512,
  parameter int unsigned WAKE_WIN    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          PORT_RST_EN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_rst_i,
  input  logic [3:0] port_i,
  input  logic       wdog_req_i,
  input  logic       wdog_en_i,
  input  logic       osc_stop_i,
  input  logic       sleep_i,
  input  logic       deb_long_i,
  input  logic       flag_rd_i,
  output logic [4:0] flags_o,
  output logic       sys_rst_no,
  output logic       status_o
);

  localparam int unsigned PORT_W = 4;

  logic     pin_s, osc_s;
  logic     por_active;
  logic     pin_req, port_req, wdog_req, osc_req;
  src_vec_t src;
  logic     rst_req, rst_q, rst_d, onset;

  sysrst_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_async_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({osc_stop_i, pin_rst_i}),
    .q_o   ({osc_s, pin_s})
  );

  sysrst_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_o(por_active)
  );

  sysrst_pin_filter #(
    .DEB_SHORT(DEB_SHORT),
    .DEB_LONG (DEB_LONG),
    .WAKE_WIN (WAKE_WIN)
  ) u_pin_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (pin_s),
    .long_sel_i  (deb_long_i),
    .sleep_i     (sleep_i),
    .por_active_i(por_active),
    .req_o       (pin_req)
  );

  generate
    if (PORT_RST_EN) begin : g_port
      logic [PORT_W-1:0] port_s;
      logic              all_hi;
      logic              hold_q;

      sysrst_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (port_i),
        .q_o   (port_s)
      );

      assign all_hi = &port_s;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q <= 1'b0;
        else         hold_q <= all_hi;
      end

      assign port_req = all_hi & hold_q;
    end else begin : g_no_port
      assign port_req = 1'b0;
    end
  endgenerate

  assign wdog_req = wdog_en_i & wdog_req_i;
  assign osc_req  = osc_s & ~sleep_i;

  always_comb begin
    src           = '0;
    src[SRC_POR]  = por_active;
    src[SRC_PIN]  = pin_req;
    src[SRC_PORT] = port_req;
    src[SRC_WDOG] = wdog_req;
    src[SRC_OSC]  = osc_req;
  end

  assign rst_req = |src;
  assign onset   = rst_req & ~rst_q;
  assign rst_d   = rst_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b1;
    else         rst_q <= rst_d;
  end

  sysrst_cause u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .onset_i(onset),
    .src_i  (src),
    .rd_i   (flag_rd_i),
    .flags_o(flags_o)
  );

  assign status_o   = rst_q;
  assign sys_rst_no = ~rst_q;

endmodule

// File: rtl/sysrst_ctrl_chk.sv
module sysrst_ctrl_chk #(
  parameter int unsigned POR_CYCLES = 32768
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wdog_req_i,
  input logic       wdog_en_i,
  input logic       osc_sync_i,
  input logic       sleep_i,
  input logic       flag_rd_i,
  input logic [4:0] flags_i,
  input logic       status_i
);

  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         edges_q <= '0;
    else if (edges_q != CW'(POR_CYCLES)) edges_q <= edges_q + 1'b1;
  end

  // R1: reset holds throughout the power-on window
  a_r1_por_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q < CW'(POR_CYCLES)) |-> status_i);

  // R6: an enabled watchdog request resets at the next edge
  a_r6_wdog_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_en_i && wdog_req_i) |=> status_i);

  // R7: a synchronized oscillator stop outside sleep resets
  a_r7_osc_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_sync_i && !sleep_i) |=> status_i);

  // R9: every reset onset leaves at least one cause bit
  a_r9_onset_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i) |-> (flags_i != 5'b0));

  // R10: a read while a reset is in force clears the flags
  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && status_i) |=> (flags_i == 5'b0));

endmodule

bind sysrst_ctrl sysrst_ctrl_chk #(.POR_CYCLES(POR_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wdog_req_i(wdog_req_i),
  .wdog_en_i (wdog_en_i),
  .osc_sync_i(osc_s),
  .sleep_i   (sleep_i),
  .flag_rd_i (flag_rd_i),
  .flags_i   (flags_o),
  .status_i  (status_o)
);

// File: tb/sysrst_ctrl_bench.sv
module sysrst_ctrl_bench;

  localparam int unsigned BENCH_POR = 300;
  localparam int unsigned SHORT_L   = 64;
  localparam int unsigned WAKE_W    = 8;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       pin_rst, wdog_req, wdog_en, osc_stop, sleep, deb_long, flag_rd;
  logic [3:0] port;
  logic [4:0] flags_o;
  logic       sys_rst_no, status_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic seen = 1'b0;

  always #2 clk = ~clk;

  sysrst_ctrl #(.POR_CYCLES(BENCH_POR)) u_sysrst_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .pin_rst_i (pin_rst),
    .port_i    (port),
    .wdog_req_i(wdog_req),
    .wdog_en_i (wdog_en),
    .osc_stop_i(osc_stop),
    .sleep_i   (sleep),
    .deb_long_i(deb_long),
    .flag_rd_i (flag_rd),
    .flags_o   (flags_o),
    .sys_rst_no(sys_rst_no),
    .status_o  (status_o)
  );

  always @(negedge clk) if (status_o) seen <= 1'b1;

  // kind: 0 pin, 1 port all high, 2 port 4'h7, 3 watchdog, 4 osc stop
  typedef struct packed {
    logic [2:0] kind;
    logic [9:0] hold;
    logic       lng;
    logic       slp;
    logic       wen;
    logic       exp_rst;
    logic [4:0] exp_flags;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 10'd63,  1'b0, 1'b0, 1'b0, 1'b0, 5'b00000},
    '{3'd0, 10'd64,  1'b0, 1'b0, 1'b0, 1'b1, 5'b00010},
    '{3'd0, 10'd64,  1'b1, 1'b0, 1'b0, 1'b0, 5'b00000},
    '{3'd0, 10'd511, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000},
    '{3'd0, 10'd512, 1'b1, 1'b0, 1'b0, 1'b1, 5'b00010},
    '{3'd0, 10'd2,   1'b0, 1'b1, 1'b0, 1'b1, 5'b00010},
    '{3'd1, 10'd1,   1'b0, 1'b0, 1'b0, 1'b0, 5'b00000},
    '{3'd1, 10'd2,   1'b0, 1'b0, 1'b0, 1'b1, 5'b00100},
    '{3'd2, 10'd20,  1'b0, 1'b0, 1'b0, 1'b0, 5'b00000},
    '{3'd3, 10'd1,   1'b0, 1'b0, 1'b1, 1'b1, 5'b01000},
    '{3'd3, 10'd5,   1'b0, 1'b0, 1'b0, 1'b0, 5'b00000},
    '{3'd4, 10'd3,   1'b0, 1'b0, 1'b0, 1'b1, 5'b10000},
    '{3'd4, 10'd10,  1'b0, 1'b1, 1'b0, 1'b0, 5'b00000}
  };

  function automatic string tag_of(vec_t v);
    case (v.kind)
      3'd0:    return v.slp ? "R4" : (v.lng ? "R3" : "R2");
      3'd1,
      3'd2:    return "R5";
      3'd3:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic read_flags();
    flag_rd = 1'b1;
    step(1);
    flag_rd = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; pin_rst = 1'b0; port = 4'h0; wdog_req = 1'b0; wdog_en = 1'b0;
    osc_stop = 1'b0; sleep = 1'b0; deb_long = 1'b0; flag_rd = 1'b0;
    step(3);
    // R1 R11 R9: state while the power-on event is low
    check("R1", "status in reset", 32'(status_o), 32'd1);
    check("R11", "sys_rst_no in reset", 32'(sys_rst_no), 32'd0);
    check("R9", "flags in reset", 32'(flags_o), 32'h01);
    rst_ni = 1'b1;
    step(BENCH_POR);
    check("R1", "status at last hold edge", 32'(status_o), 32'd1);
    step(1);
    check("R1", "status after hold", 32'(status_o), 32'd0);
    check("R11", "sys_rst_no after hold", 32'(sys_rst_no), 32'd1);
    read_flags();
    check("R10", "flags after read", 32'(flags_o), 32'h00);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      deb_long = VECS[v].lng; sleep = VECS[v].slp; wdog_en = VECS[v].wen;
      step(4);
      seen = 1'b0;
      case (VECS[v].kind)
        3'd0:    pin_rst  = 1'b1;
        3'd1:    port     = 4'hF;
        3'd2:    port     = 4'h7;
        3'd3:    wdog_req = 1'b1;
        default: osc_stop = 1'b1;
      endcase
      step(int'(VECS[v].hold));
      pin_rst = 1'b0; port = 4'h0; wdog_req = 1'b0; osc_stop = 1'b0;
      step(20);
      check(tag_of(VECS[v]), $sformatf("vector %0d reset seen", v), 32'(seen), 32'(VECS[v].exp_rst));
      check("R9", $sformatf("vector %0d flags", v), 32'(flags_o), 32'(VECS[v].exp_flags));
      sleep = 1'b0; wdog_en = 1'b0; deb_long = 1'b0;
      read_flags();
      step(WAKE_W + 4);
    end

    // R2 R8: exact pin threshold and release timing, short length
    pin_rst = 1'b1;
    step(SHORT_L + 1);
    check("R2", "status one edge before threshold", 32'(status_o), 32'd0);
    step(1);
    check("R2", "status at threshold", 32'(status_o), 32'd1);
    pin_rst = 1'b0;
    step(2);
    check("R8", "status two edges after pin low", 32'(status_o), 32'd1);
    step(1);
    check("R8", "status three edges after pin low", 32'(status_o), 32'd0);
    check("R11", "sys_rst_no after release", 32'(sys_rst_no), 32'd1);
    read_flags();

    // R6 R8: one-cycle watchdog request
    wdog_en = 1'b1; wdog_req = 1'b1;
    step(1);
    check("R6", "status after watchdog", 32'(status_o), 32'd1);
    wdog_req = 1'b0;
    step(1);
    check("R8", "status one edge after watchdog drop", 32'(status_o), 32'd0);
    check("R9", "flags after watchdog", 32'(flags_o), 32'h08);
    wdog_en = 1'b0;

    // R7 R9: oscillator stop overwrites older unread flags
    osc_stop = 1'b1;
    step(3);
    check("R7", "status after osc stop", 32'(status_o), 32'd1);
    osc_stop = 1'b0;
    step(4);
    check("R9", "flags overwritten by osc", 32'(flags_o), 32'h10);
    read_flags();
    check("R10", "flags cleared", 32'(flags_o), 32'h00);

    // R4: wake window after sleep ends, then the window closed
    sleep = 1'b1;
    step(4);
    seen = 1'b0;
    sleep = 1'b0; pin_rst = 1'b1;
    step(2);
    pin_rst = 1'b0;
    step(10);
    check("R4", "short pulse inside wake window", 32'(seen), 32'd1);
    check("R9", "flags after wake pulse", 32'(flags_o), 32'h02);
    read_flags();
    step(WAKE_W + 10);
    seen = 1'b0;
    pin_rst = 1'b1;
    step(2);
    pin_rst = 1'b0;
    step(10);
    check("R4", "short pulse after wake window", 32'(seen), 32'd0);

    // R1: asynchronous power-on event mid-run
    rst_ni = 1'b0;
    #1;
    check("R1", "status on async reset", 32'(status_o), 32'd1);
    check("R9", "flags on async reset", 32'(flags_o), 32'h01);
    step(2);
    rst_ni = 1'b1;
    step(BENCH_POR + 1);
    check("R1", "status after second hold", 32'(status_o), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout, run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule